// File: doc/BRIEF.md
# BCD Time and Calendar Counter Core

This block keeps wall-clock time and a calendar date as packed BCD words and advances them once per second. A one-cycle pulse on `tick` (derived elsewhere from a slow oscillator) marks each second. A host owns a small register port with four locations: a control word carrying two update-request bits, a mode word selecting 12- or 24-hour counting, the time word and the calendar word. Reads are combinational from `rd_addr`. Writes are single-cycle strobes that are always taken, so the port has no back-pressure and no ready signal.

To change the time or the date, the host sets the matching request bit in the control word. This freezes that set of counters. At the next second boundary the block raises `upd_ack`, and only then are writes to the time or calendar word accepted. Clearing both request bits drops the acknowledge and lets counting resume. Loads therefore never coincide with a carry.

Three registered event pulses go to a status block: `sec_evt` on every tick, `min_evt` when counting changes the minute, and `day_evt` when counting changes the day. Leap years are handled for the range 1900 to 2099, with 1900 not a leap year and 2000 a leap year.

Top module: `bcd_rtc_core`

## Requirements
- R1: Time word at address 2: seconds BCD in bits 6:0, minutes BCD in bits 14:8, hours BCD in bits 21:16, PM flag in bit 22 (1 = PM); other bits read 0. After reset it reads 00:00:00 with the flag clear.
- R2: Calendar word at address 3: century BCD in bits 6:0, year BCD in bits 15:8, month BCD 01-12 in bits 20:16, weekday 1-7 in bits 23:21, date BCD in bits 29:24; other bits read 0. After reset it holds 1900, month 01, date 01, weekday 1.
- R3: A write to the time word takes effect only while control bit 0 is set and `upd_ack` is high. A write to the calendar word takes effect only while control bit 1 is set and `upd_ack` is high. Any other write to these words is ignored.
- R4: Control word at address 0 (bit 0 = time request, bit 1 = calendar request, readable back). While bit 0 is set the time word does not advance. While bit 1 is set the calendar word does not advance. The unfrozen half keeps counting, and a day carry that arrives while the calendar is frozen is lost.
- R5: `upd_ack` rises on the first tick after a request bit becomes set, never before. It falls at the same edge at which the control word is written with both request bits clear.
- R6: `sec_evt` is high for the one cycle after every tick, whether or not counting is frozen.
- R7: In 24-hour mode, seconds roll 59 to 00 into minutes, minutes roll 59 to 00 into hours, and hours roll 23 to 00 with a day carry.
- R8: Mode word at address 1, bit 0 set selects 12-hour mode. In this mode, 11:59:59 rolls to 12:00:00 with the PM flag toggled, a day carry occurs only when leaving PM, and 12:59:59 rolls to 01:00:00 with the flag unchanged.
- R9: On a day carry the date rolls to 01 after the month's last day. Month lengths are 30 for months 4, 6, 9 and 11, and 31 for the other months except February. February has 29 days when the year is divisible by 4, except year 00 of century 19, and 28 days otherwise.
- R10: Weekday steps 1 to 7 and wraps to 1 on each day carry. Month 12 wraps to 01 and increments the year. Year 99 wraps to 00 and increments the century.
- R11: `min_evt` is high for one cycle when counting changes the minute. `day_evt` is high for one cycle when counting changes the day. Loads raise neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse per second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 mode, 2 time, 3 calendar) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Combinational read data |
| upd_ack | output | 1 | Counters frozen, loads allowed |
| sec_evt | output | 1 | Per-second event pulse |
| min_evt | output | 1 | Minute-change event pulse |
| day_evt | output | 1 | Day-change event pulse |

## Verification
The assertions check, on every cycle, the properties that hold across cycles. A frozen word stays stable unless it is being loaded. The acknowledge exists only while a request is pending and rises only at a tick. Every event pulse follows a tick or a day carry. The time and calendar words change only at a tick or through a permitted load. The bench scenarios are the only way to show that the arithmetic is right: month lengths, the leap-year rule including 1900 and 2000, the weekday, month, year and century wraps, and the 12-hour AM/PM sequencing. The scenarios also show that rejected writes leave the words as they were.

// File: rtl/rtc_core_pkg.sv
`timescale 1ns/1ps
package rtc_core_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_MODE = 2'd1;
  localparam logic [ADDR_W-1:0] A_TIME = 2'd2;
  localparam logic [ADDR_W-1:0] A_CAL  = 2'd3;

  localparam int REQ_TIME = 0;
  localparam int REQ_CAL  = 1;

  // two-digit BCD increment, 99 wraps to 00
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) begin
      r[3:0] = 4'd0;
      r[7:4] = (v[7:4] >= 4'd9) ? 4'd0 : v[7:4] + 4'd1;
    end else begin
      r = {v[7:4], v[3:0] + 4'd1};
    end
    return r;
  endfunction

  function automatic logic is_leap(input logic [6:0] cent, input logic [7:0] yr);
    logic [4:0] m;
    m = {v_ext(yr[7:4]), 1'b0} + {1'b0, yr[3:0]};
    return (m[1:0] == 2'b00) && !(cent == 7'h19 && yr == 8'h00);
  endfunction

  function automatic logic [3:0] v_ext(input logic [3:0] t);
    return t;
  endfunction

  // last day of month, BCD
  function automatic logic [5:0] month_len(input logic [4:0] mon,
                                           input logic [6:0] cent,
                                           input logic [7:0] yr);
    case (mon)
      5'h02:                      return is_leap(cent, yr) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_upd_ctrl.sv
`timescale 1ns/1ps
module rtc_upd_ctrl
  import rtc_core_pkg::*;
#(
  parameter int NREQ = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            ctrl_we,
  input  logic [NREQ-1:0] ctrl_wdata,
  output logic [NREQ-1:0] req,
  output logic            ack
);
  logic [NREQ-1:0] req_q, req_nxt;
  logic            ack_q;

  assign req_nxt = ctrl_we ? ctrl_wdata : req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      ack_q <= 1'b0;
    end else begin
      req_q <= req_nxt;
      if (req_nxt == '0)              ack_q <= 1'b0;
      else if (tick && req_q != '0)   ack_q <= 1'b1;
    end
  end

  assign req = req_q;
  assign ack = ack_q;

  assert_ack_has_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> (req_q != '0));
  assert_ack_after_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> $past(tick));
endmodule

// File: rtl/rtc_time_ctr.sv
`timescale 1ns/1ps
module rtc_time_ctr
  import rtc_core_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         hold,
  input  logic         mode12,
  input  logic         ld,
  input  logic [W-1:0] ld_data,
  output logic [W-1:0] time_w,
  output logic         day_carry,
  output logic         min_evt
);
  logic [6:0] sec_q, min_q;
  logic [5:0] hr_q;
  logic       pm_q;
  logic       min_evt_q;
  logic       adv, sec_wrap, min_wrap;
  logic [7:0] sec_inc, min_inc, hr_inc;
  logic [5:0] hr_nxt;
  logic       pm_nxt, hr_day;

  assign adv      = tick && !hold;
  assign sec_wrap = (sec_q == 7'h59);
  assign min_wrap = (min_q == 7'h59);
  assign sec_inc  = bcd_inc({1'b0, sec_q});
  assign min_inc  = bcd_inc({1'b0, min_q});
  assign hr_inc   = bcd_inc({2'b00, hr_q});

  always_comb begin
    hr_nxt = hr_inc[5:0];
    pm_nxt = pm_q;
    hr_day = 1'b0;
    if (mode12) begin
      if (hr_q == 6'h11) begin
        hr_nxt = 6'h12;
        pm_nxt = !pm_q;
        hr_day = pm_q;
      end else if (hr_q == 6'h12) begin
        hr_nxt = 6'h01;
      end
    end else if (hr_q == 6'h23) begin
      hr_nxt = 6'h00;
      hr_day = 1'b1;
    end
  end

  assign day_carry = adv && sec_wrap && min_wrap && hr_day;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q     <= '0;
      min_q     <= '0;
      hr_q      <= '0;
      pm_q      <= 1'b0;
      min_evt_q <= 1'b0;
    end else begin
      min_evt_q <= adv && sec_wrap;
      if (ld) begin
        sec_q <= ld_data[6:0];
        min_q <= ld_data[14:8];
        hr_q  <= ld_data[21:16];
        pm_q  <= ld_data[22];
      end else if (adv) begin
        sec_q <= sec_wrap ? 7'h00 : sec_inc[6:0];
        if (sec_wrap) begin
          min_q <= min_wrap ? 7'h00 : min_inc[6:0];
          if (min_wrap) begin
            hr_q <= hr_nxt;
            pm_q <= pm_nxt;
          end
        end
      end
    end
  end

  assign time_w  = {{(W-23){1'b0}}, pm_q, hr_q, 1'b0, min_q, 1'b0, sec_q};
  assign min_evt = min_evt_q;

  assert_time_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !ld) |=> $stable(time_w));
  assert_min_evt_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    min_evt |-> $past(tick));
endmodule

// File: rtl/rtc_cal_ctr.sv
`timescale 1ns/1ps
module rtc_cal_ctr
  import rtc_core_pkg::*;
#(
  parameter int         W        = REG_W,
  parameter logic [6:0] RST_CENT = 7'h19,
  parameter logic [7:0] RST_YEAR = 8'h00
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         day_inc,
  input  logic         hold,
  input  logic         ld,
  input  logic [W-1:0] ld_data,
  output logic [W-1:0] cal_w,
  output logic         day_evt
);
  logic [6:0] cent_q;
  logic [7:0] yr_q;
  logic [4:0] mon_q;
  logic [2:0] wd_q;
  logic [5:0] date_q;
  logic       day_evt_q;
  logic       adv, date_wrap, mon_wrap, yr_wrap;
  logic [7:0] date_inc, mon_inc, yr_inc, cent_inc;

  assign adv       = day_inc && !hold;
  assign date_wrap = (date_q == month_len(mon_q, cent_q, yr_q));
  assign mon_wrap  = (mon_q == 5'h12);
  assign yr_wrap   = (yr_q == 8'h99);
  assign date_inc  = bcd_inc({2'b00, date_q});
  assign mon_inc   = bcd_inc({3'b000, mon_q});
  assign yr_inc    = bcd_inc(yr_q);
  assign cent_inc  = bcd_inc({1'b0, cent_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cent_q    <= RST_CENT;
      yr_q      <= RST_YEAR;
      mon_q     <= 5'h01;
      wd_q      <= 3'd1;
      date_q    <= 6'h01;
      day_evt_q <= 1'b0;
    end else begin
      day_evt_q <= adv;
      if (ld) begin
        cent_q <= ld_data[6:0];
        yr_q   <= ld_data[15:8];
        mon_q  <= ld_data[20:16];
        wd_q   <= ld_data[23:21];
        date_q <= ld_data[29:24];
      end else if (adv) begin
        wd_q   <= (wd_q == 3'd7) ? 3'd1 : wd_q + 3'd1;
        date_q <= date_wrap ? 6'h01 : date_inc[5:0];
        if (date_wrap) begin
          mon_q <= mon_wrap ? 5'h01 : mon_inc[4:0];
          if (mon_wrap) begin
            yr_q <= yr_inc;
            if (yr_wrap) cent_q <= cent_inc[6:0];
          end
        end
      end
    end
  end

  assign cal_w   = {{(W-30){1'b0}}, date_q, wd_q, mon_q, yr_q, 1'b0, cent_q};
  assign day_evt = day_evt_q;

  assert_cal_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !ld) |=> $stable(cal_w));
  assert_day_evt_carry_R11: assert property (@(posedge clk) disable iff (!rst_n)
    day_evt |-> $past(day_inc));
endmodule

// File: rtl/bcd_rtc_core.sv
`timescale 1ns/1ps
module bcd_rtc_core
  import rtc_core_pkg::*;
#(
  parameter int DW = REG_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          upd_ack,
  output logic          sec_evt,
  output logic          min_evt,
  output logic          day_evt
);
  localparam int NREQ = 2;

  logic [NREQ-1:0] req;
  logic            ack;
  logic            mode12_q, sec_evt_q;
  logic            ctrl_we, time_ld, cal_ld, day_carry;
  logic [DW-1:0]   time_w, cal_w;

  assign ctrl_we = wr_en && (wr_addr == A_CTRL);
  assign time_ld = wr_en && (wr_addr == A_TIME) && req[REQ_TIME] && ack;
  assign cal_ld  = wr_en && (wr_addr == A_CAL)  && req[REQ_CAL]  && ack;

  rtc_upd_ctrl #(.NREQ(NREQ)) u_upd (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .ctrl_we(ctrl_we), .ctrl_wdata(wr_data[NREQ-1:0]),
    .req(req), .ack(ack)
  );

  rtc_time_ctr #(.W(DW)) u_time (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hold(req[REQ_TIME]),
    .mode12(mode12_q), .ld(time_ld), .ld_data(wr_data),
    .time_w(time_w), .day_carry(day_carry), .min_evt(min_evt)
  );

  rtc_cal_ctr #(.W(DW)) u_cal (
    .clk(clk), .rst_n(rst_n), .day_inc(day_carry), .hold(req[REQ_CAL]),
    .ld(cal_ld), .ld_data(wr_data), .cal_w(cal_w), .day_evt(day_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode12_q  <= 1'b0;
      sec_evt_q <= 1'b0;
    end else begin
      sec_evt_q <= tick;
      if (wr_en && wr_addr == A_MODE) mode12_q <= wr_data[0];
    end
  end

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = {{(DW-NREQ){1'b0}}, req};
      A_MODE:  rd_data = {{(DW-1){1'b0}}, mode12_q};
      A_TIME:  rd_data = time_w;
      default: rd_data = cal_w;
    endcase
  end

  assign upd_ack = ack;
  assign sec_evt = sec_evt_q;

  assert_sec_evt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> sec_evt);
  assert_time_ld_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(time_w) |-> ($past(tick) || $past(wr_en && wr_addr == A_TIME && ack)));
  assert_cal_ld_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cal_w) |-> ($past(tick) || $past(wr_en && wr_addr == A_CAL && ack)));
endmodule

// File: tb/bcd_rtc_core_bench.sv
`timescale 1ns/1ps
module bcd_rtc_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        upd_ack, sec_evt, min_evt, day_evt;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct { logic [1:0] a; logic [31:0] v; string tag; } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  bcd_rtc_core u_bcd_rtc_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .upd_ack(upd_ack), .sec_evt(sec_evt), .min_evt(min_evt), .day_evt(day_evt)
  );

  function automatic logic [31:0] mk_time(input logic pm, input logic [7:0] h,
                                          input logic [7:0] m, input logic [7:0] s);
    return {9'b0, pm, h[5:0], 1'b0, m[6:0], 1'b0, s[6:0]};
  endfunction

  function automatic logic [31:0] mk_cal(input logic [7:0] c, input logic [7:0] y,
                                         input logic [7:0] mo, input logic [2:0] wd,
                                         input logic [7:0] d);
    return {2'b0, d[5:0], wd, mo[4:0], y, 1'b0, c[6:0]};
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops expected register contents and compares
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        exp_t it;
        it = sb.pop_front();
        rd_addr = it.a;
        #1;
        check(rd_data == it.v, it.tag, rd_data, it.v);
      end
    end
  end

  task automatic expect_reg(input logic [1:0] a, input logic [31:0] v, input string tag);
    exp_t it;
    it.a = a; it.v = v; it.tag = tag;
    sb.push_back(it);
    while (sb.size() != 0) @(posedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic load(input logic [31:0] t, input logic [31:0] c);
    wr(2'd0, 32'd3);
    do_tick();
    wr(2'd2, t);
    wr(2'd3, c);
    wr(2'd0, 32'd0);
  endtask

  // load a calendar at 23:59:59, tick, expect the next date
  task automatic day_roll(input logic [31:0] c0, input logic [31:0] c1, input string tag);
    load(mk_time(0, 8'h23, 8'h59, 8'h59), c0);
    do_tick();
    check(day_evt == 1'b1, {tag, " day_evt"}, {31'b0, day_evt}, 32'd1);
    expect_reg(2'd3, c1, tag);
  endtask

  initial begin
    #(20 * 150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset values
    expect_reg(2'd2, 32'h0, "R1 reset time");
    expect_reg(2'd3, mk_cal(8'h19, 8'h00, 8'h01, 3'd1, 8'h01), "R2 reset calendar");
    check(upd_ack == 1'b0, "R5 ack low after reset", {31'b0, upd_ack}, 32'd0);

    // request, write before ack is ignored
    wr(2'd0, 32'd3);
    expect_reg(2'd0, 32'd3, "R4 control readback");
    check(upd_ack == 1'b0, "R5 no ack before tick", {31'b0, upd_ack}, 32'd0);
    wr(2'd2, mk_time(0, 8'h05, 8'h05, 8'h05));
    expect_reg(2'd2, 32'h0, "R3 time write ignored without ack");
    do_tick();
    check(upd_ack == 1'b1, "R5 ack after tick", {31'b0, upd_ack}, 32'd1);
    check(sec_evt == 1'b1, "R6 sec_evt while frozen", {31'b0, sec_evt}, 32'd1);
    expect_reg(2'd2, 32'h0, "R4 time frozen");
    wr(2'd2, mk_time(0, 8'h23, 8'h59, 8'h58));
    wr(2'd3, mk_cal(8'h20, 8'h24, 8'h02, 3'd3, 8'h28));
    expect_reg(2'd2, mk_time(0, 8'h23, 8'h59, 8'h58), "R3 time loaded");
    expect_reg(2'd3, mk_cal(8'h20, 8'h24, 8'h02, 3'd3, 8'h28), "R3 calendar loaded");
    wr(2'd0, 32'd0);
    check(upd_ack == 1'b0, "R5 ack drops on clear", {31'b0, upd_ack}, 32'd0);

    do_tick();
    check(min_evt == 1'b0, "R11 no min_evt mid-minute", {31'b0, min_evt}, 32'd0);
    expect_reg(2'd2, mk_time(0, 8'h23, 8'h59, 8'h59), "R7 second increments");
    do_tick();
    check(min_evt == 1'b1, "R11 min_evt at rollover", {31'b0, min_evt}, 32'd1);
    check(day_evt == 1'b1, "R11 day_evt at midnight", {31'b0, day_evt}, 32'd1);
    expect_reg(2'd2, 32'h0, "R7 midnight wrap");
    expect_reg(2'd3, mk_cal(8'h20, 8'h24, 8'h02, 3'd4, 8'h29), "R9 leap 2024 Feb 29");

    day_roll(mk_cal(8'h20, 8'h23, 8'h02, 3'd2, 8'h28),
             mk_cal(8'h20, 8'h23, 8'h03, 3'd3, 8'h01), "R9 2023 Feb 28 to Mar 1");
    day_roll(mk_cal(8'h19, 8'h00, 8'h02, 3'd4, 8'h28),
             mk_cal(8'h19, 8'h00, 8'h03, 3'd5, 8'h01), "R9 1900 not leap");
    day_roll(mk_cal(8'h20, 8'h00, 8'h02, 3'd2, 8'h28),
             mk_cal(8'h20, 8'h00, 8'h02, 3'd3, 8'h29), "R9 2000 leap");
    day_roll(mk_cal(8'h20, 8'h24, 8'h04, 3'd2, 8'h30),
             mk_cal(8'h20, 8'h24, 8'h05, 3'd3, 8'h01), "R9 30-day month");
    day_roll(mk_cal(8'h20, 8'h24, 8'h01, 3'd3, 8'h30),
             mk_cal(8'h20, 8'h24, 8'h01, 3'd4, 8'h31), "R9 January 30 to 31");
    day_roll(mk_cal(8'h19, 8'h99, 8'h12, 3'd7, 8'h31),
             mk_cal(8'h20, 8'h00, 8'h01, 3'd1, 8'h01), "R10 century and weekday wrap");

    // minute change without day change
    load(mk_time(0, 8'h10, 8'h15, 8'h59), mk_cal(8'h20, 8'h24, 8'h06, 3'd1, 8'h10));
    do_tick();
    check(min_evt == 1'b1, "R11 min_evt", {31'b0, min_evt}, 32'd1);
    check(day_evt == 1'b0, "R11 no day_evt", {31'b0, day_evt}, 32'd0);
    expect_reg(2'd2, mk_time(0, 8'h10, 8'h16, 8'h00), "R7 minute carry");

    // 12-hour mode
    wr(2'd1, 32'd1);
    expect_reg(2'd1, 32'd1, "R8 mode readback");
    load(mk_time(0, 8'h11, 8'h59, 8'h59), mk_cal(8'h20, 8'h24, 8'h06, 3'd1, 8'h10));
    do_tick();
    check(day_evt == 1'b0, "R8 noon no day_evt", {31'b0, day_evt}, 32'd0);
    expect_reg(2'd2, mk_time(1, 8'h12, 8'h00, 8'h00), "R8 AM to PM noon");
    expect_reg(2'd3, mk_cal(8'h20, 8'h24, 8'h06, 3'd1, 8'h10), "R8 date kept at noon");
    load(mk_time(1, 8'h12, 8'h59, 8'h59), mk_cal(8'h20, 8'h24, 8'h06, 3'd1, 8'h10));
    do_tick();
    expect_reg(2'd2, mk_time(1, 8'h01, 8'h00, 8'h00), "R8 12 to 01 keeps PM");
    load(mk_time(1, 8'h11, 8'h59, 8'h59), mk_cal(8'h20, 8'h24, 8'h06, 3'd1, 8'h10));
    do_tick();
    check(day_evt == 1'b1, "R8 midnight day_evt", {31'b0, day_evt}, 32'd1);
    expect_reg(2'd2, mk_time(0, 8'h12, 8'h00, 8'h00), "R8 PM to AM midnight");
    expect_reg(2'd3, mk_cal(8'h20, 8'h24, 8'h06, 3'd2, 8'h11), "R8 date advances");
    wr(2'd1, 32'd0);

    // calendar-only freeze: time keeps running, time write rejected
    load(mk_time(0, 8'h08, 8'h00, 8'h00), mk_cal(8'h20, 8'h24, 8'h06, 3'd1, 8'h10));
    wr(2'd0, 32'd2);
    do_tick();
    check(upd_ack == 1'b1, "R5 ack for calendar request", {31'b0, upd_ack}, 32'd1);
    expect_reg(2'd2, mk_time(0, 8'h08, 8'h00, 8'h01), "R4 time runs during calendar freeze");
    wr(2'd2, mk_time(0, 8'h09, 8'h09, 8'h09));
    expect_reg(2'd2, mk_time(0, 8'h08, 8'h00, 8'h01), "R3 time write ignored without its request");
    wr(2'd3, mk_cal(8'h20, 8'h25, 8'h07, 3'd5, 8'h04));
    expect_reg(2'd3, mk_cal(8'h20, 8'h25, 8'h07, 3'd5, 8'h04), "R3 calendar-only load");
    wr(2'd0, 32'd0);
    check(upd_ack == 1'b0, "R5 ack cleared", {31'b0, upd_ack}, 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule